// File: doc/BRIEF.md
# Single-Line Burst Read Cache

This block sits between a CPU read port and an SDRAM controller that always delivers four-word bursts. It keeps exactly one cacheline, the size of one burst, tagged by the line-aligned word address. A read that falls inside the stored line is answered combinationally, in the cycle it is presented. A read outside the line, or any read while the line is invalid, starts a refill. The block asks the controller for the whole burst, stores the four words in arrival order, and then serves the waiting read from the refreshed line. A stream of sequential reads therefore stalls once per four words.

CPU writes go to memory by another path. The block only observes them, so that its stored copy stays coherent. A write that hits the valid line overwrites that word in place. A write to the line that is being refilled marks the refill as stale, so the line is left invalid and the waiting read fetches the line again.

Top module: `burst_line_cache`

## Requirements
- R1: After reset the line is invalid: `mem_req` and `cpu_ack` are low, and the first read of any address misses.
- R2: When `cpu_rd` is high, the line is valid and the read address shifted right by two equals the stored tag, `cpu_ack` is high in the same cycle and `cpu_rdata` holds the word selected by address bits [1:0], with no memory request.
- R3: One cycle after a missing read is presented, `mem_req` is high for exactly one cycle, and `mem_addr` is the read address with bits [1:0] forced to zero.
- R4: Each `mem_rvalid` beat during a refill writes word 0, 1, 2 and then 3 of the line, in arrival order. Beats may be separated by idle cycles. The line becomes valid at the clock edge that captures the fourth beat. `cpu_ack` for the waiting read rises in the following cycle, and never earlier.
- R5: Reading addresses in ascending order causes exactly one memory request per four-word line, and every read returns the memory contents.
- R6: A `cpu_wr` pulse whose address hits the valid line, with no refill in progress, replaces the addressed word. A later read of that address hits and returns the new value.
- R7: A `cpu_wr` whose address lies outside the cached line changes nothing in the cached line and issues no memory request.
- R8: A `cpu_wr` to the line being refilled, during the request or fill cycles, leaves the line invalid after the fourth beat. The waiting read then issues a second request and returns the memory contents.
- R9: A `mem_rvalid` beat arriving while no refill is in progress is ignored, and the cached words are unchanged.
- R10: A miss to a new line replaces the single stored line, so a later read of the previous line misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_rd | input | 1 | Read request, held until `cpu_ack` |
| cpu_wr | input | 1 | One-cycle write strobe, observed for coherence |
| cpu_addr | input | ADDR_W | Word address for read or write |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data, valid while `cpu_ack` is high |
| cpu_ack | output | 1 | Read served this cycle |
| mem_req | output | 1 | One-cycle burst request to the memory controller |
| mem_addr | output | ADDR_W | Line-aligned burst start address |
| mem_rvalid | input | 1 | Burst beat valid |
| mem_rdata | input | DATA_W | Burst beat data |

## Verification
A wrong tag or valid bit shows up at once at the ports. A read that should hit raises `mem_req` one cycle later, and a read that should miss is acknowledged with zero wait. A misplaced fill beat or an in-place write to the wrong word gives a wrong `cpu_rdata` on the very next read of that word. A lost stale mark is visible as a missing second request during the interrupted refill. The latency of every read is counted exactly, so a line that becomes valid one beat early or late is also caught.

// File: rtl/bcache_pkg.sv
// Shared types for the single-line burst cache.
// Assumes: nothing beyond the parameters of the top module.
package bcache_pkg;
    // Refill sequencer states
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_FILL = 2'd2
    } fill_state_e;
endpackage

// File: rtl/bc_tag_match.sv
// Compares the line part of the CPU address with the stored tag.
// Assumes: the caller passes the address with its word-offset bits already removed.
module bc_tag_match #(
    parameter int TAG_W = 14
) (
    input  logic [TAG_W-1:0] addr_line,
    input  logic [TAG_W-1:0] tag_q,
    input  logic             valid_q,
    output logic             line_eq,
    output logic             hit
);
    // Line equality ignores valid; hit requires it
    always_comb begin
        line_eq = (addr_line == tag_q);
        hit     = valid_q && line_eq;
    end
endmodule

// File: rtl/bc_line_store.sv
// Holds the single cacheline: one word register per burst beat, plus tag and valid.
// Assumes: the fill controller never asserts beat_we and wr_en in the same cycle.
module bc_line_store #(
    parameter int DATA_W = 16,
    parameter int TAG_W  = 14,
    parameter int WORDS  = 4,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_tag,
    input  logic [TAG_W-1:0]  new_tag,
    input  logic              beat_we,
    input  logic [OFS_W-1:0]  beat_idx,
    input  logic [DATA_W-1:0] beat_data,
    input  logic              fill_done,
    input  logic              fill_keep,
    input  logic              wr_en,
    input  logic [OFS_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFS_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  tag_q,
    output logic              valid_q,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] words [WORDS];

    // One register per line word; fill beats take precedence over CPU writes
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (beat_we && beat_idx == OFS_W'(g))
                word_q <= beat_data;
            else if (wr_en && wr_idx == OFS_W'(g))
                word_q <= wr_data;
        end
        assign words[g] = word_q;
    end

    // Tag and valid: cleared on reset, dropped at refill start, set after the last beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            valid_q <= 1'b0;
        end else if (load_tag) begin
            tag_q   <= new_tag;
            valid_q <= 1'b0;
        end else if (fill_done) begin
            valid_q <= fill_keep;
        end
    end

    // Read port: word selected by the address offset
    assign rd_word = words[rd_idx];

    // A refill start must not coincide with a completing fill
    assert_no_load_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_tag |-> !fill_done);
endmodule

// File: rtl/bc_fill_ctrl.sv
// Refill sequencer: detects a read miss, issues one burst request, counts the
// four beats and decides whether the refreshed line may be marked valid.
// Assumes: the controller returns beats no earlier than the cycle after mem_req.
module bc_fill_ctrl #(
    parameter int WORDS = 4,
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic             hit,
    input  logic             wr_req,
    input  logic             wr_line_eq,
    input  logic             beat_valid,
    output logic             busy,
    output logic             fill_start,
    output logic             mem_req,
    output logic             beat_we,
    output logic [OFS_W-1:0] beat_idx,
    output logic             fill_done,
    output logic             fill_keep
);
    import bcache_pkg::*;

    fill_state_e      state_q;
    logic [OFS_W-1:0] cnt_q;
    logic             stale_q;
    logic             stale_now;

    // Decode strobes from the current state
    always_comb begin
        busy       = (state_q != FS_IDLE);
        fill_start = (state_q == FS_IDLE) && rd_req && !hit;
        mem_req    = (state_q == FS_REQ);
        beat_we    = (state_q == FS_FILL) && beat_valid;
        beat_idx   = cnt_q;
        fill_done  = beat_we && (cnt_q == OFS_W'(WORDS - 1));
        stale_now  = busy && wr_req && wr_line_eq;
        fill_keep  = !(stale_q || stale_now);
    end

    // State, beat counter and stale flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            cnt_q   <= '0;
            stale_q <= 1'b0;
        end else begin
            unique case (state_q)
                FS_IDLE: begin
                    if (fill_start) begin
                        state_q <= FS_REQ;
                        cnt_q   <= '0;
                        stale_q <= 1'b0;
                    end
                end
                FS_REQ: begin
                    state_q <= FS_FILL;
                    if (stale_now) stale_q <= 1'b1;
                end
                FS_FILL: begin
                    if (beat_we) cnt_q <= cnt_q + 1'b1;
                    if (fill_done) state_q <= FS_IDLE;
                    if (stale_now) stale_q <= 1'b1;
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // The burst request lasts exactly one cycle
    assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // A detected miss is followed by a request in the next cycle
    assert_miss_to_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_start |=> mem_req);
    // The fill stays busy until the fourth beat has been taken
    assert_busy_until_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FS_FILL && !fill_done) |=> busy);
endmodule

// File: rtl/burst_line_cache.sv
// Single-line direct-mapped read cache sized to one SDRAM burst.
// Hits are served combinationally; misses refill the whole line and the held
// read is then served from it. CPU writes keep the stored copy coherent.
// Assumes: cpu_rd is held until cpu_ack; the memory controller returns
// exactly BURST_WORDS beats per request.
module burst_line_cache #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int BURST_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ack,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int OFS_W = $clog2(BURST_WORDS);
    localparam int TAG_W = ADDR_W - OFS_W;

    logic [TAG_W-1:0] addr_line;
    logic [OFS_W-1:0] addr_ofs;
    logic [TAG_W-1:0] tag_q;
    logic             line_valid;
    logic             line_eq;
    logic             hit;
    logic             busy;
    logic             fill_start;
    logic             beat_we;
    logic [OFS_W-1:0] beat_idx;
    logic             fill_done;
    logic             fill_keep;
    logic             wr_en;

    // Split the CPU address into line and word offset
    assign addr_line = cpu_addr[ADDR_W-1:OFS_W];
    assign addr_ofs  = cpu_addr[OFS_W-1:0];

    bc_tag_match #(.TAG_W(TAG_W)) match_i (
        .addr_line (addr_line),
        .tag_q     (tag_q),
        .valid_q   (line_valid),
        .line_eq   (line_eq),
        .hit       (hit)
    );

    bc_fill_ctrl #(.WORDS(BURST_WORDS), .OFS_W(OFS_W)) fill_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (cpu_rd),
        .hit        (hit),
        .wr_req     (cpu_wr),
        .wr_line_eq (line_eq),
        .beat_valid (mem_rvalid),
        .busy       (busy),
        .fill_start (fill_start),
        .mem_req    (mem_req),
        .beat_we    (beat_we),
        .beat_idx   (beat_idx),
        .fill_done  (fill_done),
        .fill_keep  (fill_keep)
    );

    bc_line_store #(.DATA_W(DATA_W), .TAG_W(TAG_W), .WORDS(BURST_WORDS), .OFS_W(OFS_W)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_tag  (fill_start),
        .new_tag   (addr_line),
        .beat_we   (beat_we),
        .beat_idx  (beat_idx),
        .beat_data (mem_rdata),
        .fill_done (fill_done),
        .fill_keep (fill_keep),
        .wr_en     (wr_en),
        .wr_idx    (addr_ofs),
        .wr_data   (cpu_wdata),
        .rd_idx    (addr_ofs),
        .tag_q     (tag_q),
        .valid_q   (line_valid),
        .rd_word   (cpu_rdata)
    );

    // CPU-side strobes: acknowledge hits and apply write hits only when idle
    always_comb begin
        cpu_ack  = cpu_rd && hit && !busy;
        wr_en    = cpu_wr && hit && !busy;
        mem_addr = {tag_q, {OFS_W{1'b0}}};
    end

    // The line only turns valid on the edge that captures a memory beat
    assert_valid_after_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_valid) |-> $past(mem_rvalid));
    // A served read never coincides with a burst request
    assert_ack_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> !mem_req);
    // A write alone, outside a refill, never moves the tag
    assert_write_keeps_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_rd && !busy) |=> $stable(tag_q));
endmodule

// File: tb/burst_line_cache_tb.sv
`timescale 1ns/1ps
module burst_line_cache_tb_top;
    localparam int AW = 16;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_ack;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid;
    logic [DW-1:0] mem_rdata;

    logic          resp_v = 1'b0;
    logic [DW-1:0] resp_d = '0;
    logic          stray_v = 1'b0;
    logic [DW-1:0] stray_d = '0;
    assign mem_rvalid = resp_v | stray_v;
    assign mem_rdata  = stray_v ? stray_d : resp_d;

    logic [DW-1:0] mem [64];
    int total = 0;
    int bad = 0;
    int reqs = 0;
    int last_la = 0;
    bit gap_mode = 1'b0;

    always #2.5 clk = ~clk;

    burst_line_cache #(.ADDR_W(AW), .DATA_W(DW), .BURST_WORDS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ack(cpu_ack), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Burst responder: answers each request with four beats, optionally gapped
    initial begin
        forever begin
            @(negedge clk); #1;
            if (mem_req) begin
                reqs++;
                last_la = int'(mem_addr);
                for (int b = 0; b < 4; b++) begin
                    if (gap_mode && b > 0) begin
                        @(negedge clk); resp_v = 1'b0;
                    end
                    @(negedge clk);
                    resp_v = 1'b1;
                    resp_d = mem[(last_la + b) % 64];
                end
                @(negedge clk); resp_v = 1'b0;
            end
        end
    end

    task automatic do_read(input int a, output int data, output int waits);
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = AW'(a);
        waits = 0;
        #1;
        while (!cpu_ack) begin
            @(negedge clk); #1; waits++;
        end
        data = int'(cpu_rdata);
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic do_write(input int a, input int d);
        logic [AW-1:0] keep;
        @(negedge clk);
        keep = cpu_addr;
        cpu_wr = 1'b1; cpu_addr = AW'(a); cpu_wdata = DW'(d);
        mem[a] = DW'(d);
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = keep;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int d, w, r0, miss_w;
        for (int i = 0; i < 64; i++) mem[i] = DW'(i * 37 + 5);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(mem_req == 1'b0, "R1 mem_req", int'(mem_req), 0);
        chk(cpu_ack == 1'b0, "R1 cpu_ack", int'(cpu_ack), 0);
        do_read(40, d, w);
        chk(w == 6, "R1 first read misses", w, 6);
        chk(reqs == 1, "R1 request count", reqs, 1);
        chk(d == int'(mem[40]), "R1 data", d, int'(mem[40]));

        // R5/R2/R3/R4: ascending sweep, second half with gapped beats
        for (int a = 0; a < 32; a++) begin
            gap_mode = (a >= 16);
            miss_w = gap_mode ? 9 : 6;
            r0 = reqs;
            do_read(a, d, w);
            chk(d == int'(mem[a]), "R5 sweep data", d, int'(mem[a]));
            if (a % 4 == 0) begin
                chk(w == miss_w, "R4 refill latency", w, miss_w);
                chk(reqs == r0 + 1, "R3 one request", reqs, r0 + 1);
                chk(last_la == a, "R3 aligned address", last_la, a);
            end else begin
                chk(w == 0, "R2 same-cycle hit", w, 0);
                chk(reqs == r0, "R2 no request", reqs, r0);
            end
        end
        gap_mode = 1'b0;
        chk(reqs == 9, "R5 one request per line", reqs, 9);

        // R4: fill order independent of requested word
        do_read(15, d, w);
        chk(w == 6 && d == int'(mem[15]), "R4 miss on word 3", d, int'(mem[15]));
        for (int a = 14; a >= 12; a--) begin
            do_read(a, d, w);
            chk(w == 0 && d == int'(mem[a]), "R4 beat order", d, int'(mem[a]));
        end

        // R6: write hit updates in place
        r0 = reqs;
        do_write(13, 16'hBEEF);
        do_read(13, d, w);
        chk(d == 16'hBEEF, "R6 updated word", d, 16'hBEEF);
        chk(w == 0 && reqs == r0, "R6 still a hit", w, 0);

        // R7: write outside the line has no effect on the cached line
        do_write(20, 16'h1111);
        chk(reqs == r0, "R7 no request", reqs, r0);
        do_read(12, d, w);
        chk(w == 0 && d == int'(mem[12]), "R7 word 0 intact", d, int'(mem[12]));
        do_read(13, d, w);
        chk(w == 0 && d == 16'hBEEF, "R7 word 1 intact", d, 16'hBEEF);
        do_read(20, d, w);
        chk(w == 6 && d == 16'h1111, "R10 new line fetched", d, 16'h1111);

        // R9: stray beat outside a refill is ignored
        @(negedge clk); stray_v = 1'b1; stray_d = 16'hDEAD;
        @(negedge clk); stray_v = 1'b0;
        r0 = reqs;
        for (int a = 20; a < 24; a++) begin
            do_read(a, d, w);
            chk(w == 0 && d == int'(mem[a]), "R9 words unchanged", d, int'(mem[a]));
        end
        chk(reqs == r0, "R9 no request", reqs, r0);

        // R10: single line is replaced
        do_read(2, d, w);
        chk(w == 6, "R10 other line misses", w, 6);
        do_read(21, d, w);
        chk(w == 6 && reqs == r0 + 2, "R10 old line evicted", reqs, r0 + 2);

        // R8: write to the line under refill forces a second fetch
        r0 = reqs;
        fork
            do_read(8, d, w);
            begin
                wait (mem_req == 1'b1);
                do_write(11, 16'h7A7A);
            end
        join
        chk(reqs == r0 + 2, "R8 refetch", reqs, r0 + 2);
        chk(d == int'(mem[8]), "R8 data", d, int'(mem[8]));
        do_read(11, d, w);
        chk(w == 0 && d == 16'h7A7A, "R8 written word after refetch", d, 16'h7A7A);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule